// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Channel

This block moves incoming frames from a byte stream into memory buffers chosen by a ring of descriptors. Software hands the channel a run of free descriptors by moving a posted-limit pointer. The channel reads one descriptor at a time: a byte count, an end-of-ring flag and a completion-notify flag, plus a buffer address. It then writes the frame's bytes into that buffer. When a buffer fills before the frame ends, the channel fetches the next descriptor and continues there. When the frame ends, the channel writes a 4-byte status header at the very start of the frame's first buffer. The header holds the stored length, an overflow flag and the number of descriptors used.

A programmable offset leaves room at the head of the first buffer for that header. The payload starts that many bytes in, and the offset counts against the buffer's capacity. If the posted descriptors run out while a frame is still arriving, a control bit chooses what happens. Either the channel stops with an overflow error, or it absorbs and discards the rest of the frame, marks the header as overflowed and carries on.

Control is a 32-bit word with fixed bit positions. Status is a 32-bit word that shows the current ring position, the channel state and an error code. Memory traffic uses two ports: a descriptor read port that answers in the same cycle, and a byte write port with ready and error handshake signals.

Top module: `rxring_dma`

## Requirements
- R1: After reset, and while control bit 0 (enable) is clear, `status_word` reads 0 (state code 0 in bits 15:12, error 0 in bits 19:16, ring position 0 in bits 11:0), `in_ready`, `wr_valid` and `dsc_req` are low, and the ring position returns to 0.
- R2: With enable set and the ring position equal to `last_post`, the channel reports state code 2 (waiting), keeps `in_ready` low and requests no descriptor even if a frame is offered. Descriptor reads go to address `{ring_base[31:12], position}`.
- R3: The first payload byte of a frame is written at the first buffer's address plus the offset taken from control bits 7:1. Bytes follow at consecutive addresses, and the first buffer holds its byte count minus the offset.
- R4: A descriptor's byte count sits in bits 12:0. When a buffer fills before the frame ends and a further descriptor is posted, the channel reads it and continues at the start of its buffer. The position steps by 8 for each descriptor taken, and wraps to 0 after a descriptor with bit 28 (end of ring) set.
- R5: After the last byte, four header bytes are written at the first buffer's start address, in the order bits 7:0, 15:8, 23:16, 31:24 of a word. In that word, bits 15:0 hold the stored length, bit 23 holds the overflow flag, and bits 27:24 hold the number of descriptors used minus one. The channel then returns to state code 2.
- R6: If a buffer fills mid-frame with no further descriptor posted and control bit 10 is clear, the channel enters state code 3 with error code 2. It stays there, with `in_ready` low, until enable is cleared.
- R7: In that same overflow case with control bit 10 set, the rest of the frame is accepted and not written. The header is written with the overflow flag set and the stored length. The channel then handles further frames normally.
- R8: A descriptor whose byte count is 0, or a first descriptor whose byte count is not larger than the offset, stops the channel with error code 1.
- R9: A descriptor read answered with an error stops the channel with error code 4. A write answered with an error stops it with error code 3.
- R10: If any descriptor used by a frame has bit 29 (notify) set, `frame_done` is high for exactly one cycle, the cycle after the last header byte is accepted. Otherwise it stays low.
- R11: Clearing enable in any state puts the channel in state code 0 with error 0 and position 0 from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Control: bit 0 enable, bits 7:1 frame offset, bit 10 overflow-continue |
| ring_base | input | 32 | Ring base address, 4096-byte aligned |
| last_post | input | 12 | Ring byte position at which fetching must stop |
| status_word | output | 32 | Bits 11:0 position, 15:12 state code, 19:16 error code |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte ends the frame |
| in_ready | output | 1 | Channel accepts the stream byte |
| dsc_req | output | 1 | Descriptor read request |
| dsc_addr | output | 32 | Descriptor address |
| dsc_ack | input | 1 | Descriptor read answered this cycle |
| dsc_err | input | 1 | Descriptor read failed |
| dsc_ctrl | input | 32 | Descriptor control word |
| dsc_buf | input | 32 | Descriptor buffer address |
| wr_valid | output | 1 | Memory byte write valid |
| wr_addr | output | 32 | Memory byte address |
| wr_data | output | 8 | Memory byte |
| wr_ready | input | 1 | Memory takes the write |
| wr_err | input | 1 | Write accepted with error |
| frame_done | output | 1 | Completion notify pulse |

## Verification
A stream byte goes straight through to the write port in the cycle it is accepted. The header bytes follow on the next four cycles in which `wr_ready` is high. The position, state and error fields of `status_word` change at the edge that completes the descriptor read or the failing transfer, and `frame_done` rises one edge after the fourth header byte. The bench therefore drives inputs at the falling edge and samples `in_ready` shortly after it. It checks memory contents and status only after a settling window that is longer than the four header beats plus any write stalls. The bench also checks that the status word clears on the first edge after enable drops.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_FETCH,
    ST_MOVE,
    ST_DRAIN,
    ST_HEAD,
    ST_HALT
  } rx_state_e;

  // control word fields
  localparam int CTL_EN      = 0;
  localparam int CTL_OFS_LSB = 1;
  localparam int CTL_OFS_W   = 7;
  localparam int CTL_OVC     = 10;

  // descriptor control fields
  localparam int DSC_BC_W = 13;
  localparam int DSC_EOT  = 28;
  localparam int DSC_IOC  = 29;

  // status state codes
  localparam logic [3:0] STC_OFF  = 4'd0;
  localparam logic [3:0] STC_RUN  = 4'd1;
  localparam logic [3:0] STC_WAIT = 4'd2;
  localparam logic [3:0] STC_HALT = 4'd3;

  // status error codes
  localparam logic [3:0] ERR_NONE  = 4'd0;
  localparam logic [3:0] ERR_DPROT = 4'd1;
  localparam logic [3:0] ERR_OVF   = 4'd2;
  localparam logic [3:0] ERR_WBUS  = 4'd3;
  localparam logic [3:0] ERR_DBUS  = 4'd4;

  // header byte for a given lane of the frame status word
  function automatic logic [7:0] hdr_byte(input logic [15:0] len, input logic ovf,
                                          input logic [3:0] cnt, input logic [1:0] lane);
    logic [31:0] w;
    w = {4'b0000, cnt, ovf, 7'b0000000, len};
    return w[{lane, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/rxring_ptr.sv
module rxring_ptr #(
  parameter int RING_BITS = 12,
  parameter int STEP      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 adv,
  input  logic                 wrap,
  output logic [RING_BITS-1:0] cur
);

  localparam logic [RING_BITS-1:0] STEP_V = RING_BITS'(STEP);

  logic [RING_BITS-1:0] cur_n;
  logic                 cur_en;

  always_comb begin
    cur_n  = cur;
    cur_en = clr | adv;
    if (clr)      cur_n = '0;
    else if (adv) cur_n = wrap ? '0 : cur + STEP_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (cur_en) cur <= cur_n;
  end

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !clr) |=> (cur == $past(cur) + STEP_V));

  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !clr) |=> (cur == '0));

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cur));

endmodule

// File: rtl/rxring_acc.sv
module rxring_acc #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             next,
  input  logic             byte_ok,
  input  logic             set_ovf,
  input  logic             fin,
  input  logic             ioc_in,
  output logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] len_n;
  logic [CNT_W-1:0] cnt_n;
  logic             ovf_n;
  logic             ioc_q, ioc_n;
  logic             acc_en;

  always_comb begin
    len_n  = len;
    cnt_n  = cnt;
    ovf_n  = ovf;
    ioc_n  = ioc_q;
    acc_en = start | next | byte_ok | set_ovf;
    if (start) begin
      len_n = '0;
      cnt_n = '0;
      ovf_n = 1'b0;
      ioc_n = ioc_in;
    end else begin
      if (next) begin
        cnt_n = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
        ioc_n = ioc_q | ioc_in;
      end
      if (byte_ok) len_n = len + 1'b1;
      if (set_ovf) ovf_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len   <= '0;
      cnt   <= '0;
      ovf   <= 1'b0;
      ioc_q <= 1'b0;
    end else if (acc_en) begin
      len   <= len_n;
      cnt   <= cnt_n;
      ovf   <= ovf_n;
      ioc_q <= ioc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= fin & ioc_q;
  end

  p_len_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && !start) |=> (len == $past(len) + 1'b1));

  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !start) |=> ovf);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/rxring_fsm.sv
module rxring_fsm
  import rxring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BC_W  = 13,
  parameter int OFS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ovf_cont,
  input  logic [OFS_W-1:0] ofs,
  input  logic             avail,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  output logic             dsc_req,
  input  logic             dsc_ack,
  input  logic             dsc_err,
  input  logic [BC_W-1:0]  dsc_bc,
  input  logic             dsc_eot,
  input  logic [AW-1:0]    dsc_buf,
  output logic             wr_valid,
  output logic [AW-1:0]    wr_addr,
  input  logic             wr_ready,
  input  logic             wr_err,
  output rx_state_e        state,
  output logic [3:0]       err_code,
  output logic             head_phase,
  output logic [1:0]       head_idx,
  output logic             ptr_clr,
  output logic             ptr_adv,
  output logic             ptr_wrap,
  output logic             acc_start,
  output logic             acc_next,
  output logic             acc_byte,
  output logic             acc_ovf,
  output logic             acc_fin
);

  localparam logic [BC_W-1:0] BC_ONE = BC_W'(1);

  rx_state_e       st_q, st_n;
  logic            first_q, first_n;
  logic [AW-1:0]   addr_q, addr_n, hdr_q, hdr_n;
  logic [BC_W-1:0] rem_q, rem_n;
  logic [1:0]      hidx_q, hidx_n;
  logic [3:0]      err_q, err_n;
  logic            dat_en;
  logic [BC_W-1:0] ofs_w;

  assign ofs_w = BC_W'(ofs);

  always_comb begin
    st_n      = st_q;
    first_n   = first_q;
    addr_n    = addr_q;
    rem_n     = rem_q;
    hdr_n     = hdr_q;
    hidx_n    = hidx_q;
    err_n     = err_q;
    dat_en    = 1'b0;
    in_ready  = 1'b0;
    dsc_req   = 1'b0;
    wr_valid  = 1'b0;
    ptr_clr   = 1'b0;
    ptr_adv   = 1'b0;
    ptr_wrap  = 1'b0;
    acc_start = 1'b0;
    acc_next  = 1'b0;
    acc_byte  = 1'b0;
    acc_ovf   = 1'b0;
    acc_fin   = 1'b0;
    if (!enable) begin
      st_n    = ST_OFF;
      err_n   = ERR_NONE;
      ptr_clr = 1'b1;
    end else begin
      case (st_q)
        ST_OFF: st_n = ST_WAIT;
        ST_WAIT: begin
          if (in_valid && avail) begin
            st_n    = ST_FETCH;
            first_n = 1'b1;
          end
        end
        ST_FETCH: begin
          dsc_req = 1'b1;
          if (dsc_ack) begin
            if (dsc_err) begin
              st_n  = ST_HALT;
              err_n = ERR_DBUS;
            end else if (dsc_bc == '0 || (first_q && dsc_bc <= ofs_w)) begin
              st_n  = ST_HALT;
              err_n = ERR_DPROT;
            end else begin
              ptr_adv   = 1'b1;
              ptr_wrap  = dsc_eot;
              acc_start = first_q;
              acc_next  = !first_q;
              dat_en    = 1'b1;
              if (first_q) begin
                hdr_n  = dsc_buf;
                addr_n = dsc_buf + AW'(ofs);
                rem_n  = dsc_bc - ofs_w;
              end else begin
                addr_n = dsc_buf;
                rem_n  = dsc_bc;
              end
              st_n = ST_MOVE;
            end
          end
        end
        ST_MOVE: begin
          wr_valid = in_valid;
          in_ready = wr_ready;
          if (in_valid && wr_ready) begin
            if (wr_err) begin
              st_n  = ST_HALT;
              err_n = ERR_WBUS;
            end else begin
              acc_byte = 1'b1;
              dat_en   = 1'b1;
              addr_n   = addr_q + AW'(1);
              rem_n    = rem_q - BC_ONE;
              if (in_last) begin
                st_n   = ST_HEAD;
                hidx_n = 2'd0;
              end else if (rem_q == BC_ONE) begin
                if (avail) begin
                  st_n    = ST_FETCH;
                  first_n = 1'b0;
                end else if (ovf_cont) begin
                  acc_ovf = 1'b1;
                  st_n    = ST_DRAIN;
                end else begin
                  st_n  = ST_HALT;
                  err_n = ERR_OVF;
                end
              end
            end
          end
        end
        ST_DRAIN: begin
          in_ready = 1'b1;
          if (in_valid && in_last) begin
            st_n   = ST_HEAD;
            hidx_n = 2'd0;
          end
        end
        ST_HEAD: begin
          wr_valid = 1'b1;
          if (wr_ready) begin
            if (wr_err) begin
              st_n  = ST_HALT;
              err_n = ERR_WBUS;
            end else if (hidx_q == 2'd3) begin
              st_n    = ST_WAIT;
              acc_fin = 1'b1;
            end else begin
              hidx_n = hidx_q + 2'd1;
            end
          end
        end
        ST_HALT: st_n = ST_HALT;
        default: st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      first_q <= 1'b0;
      hidx_q  <= 2'd0;
      err_q   <= ERR_NONE;
    end else begin
      st_q    <= st_n;
      first_q <= first_n;
      hidx_q  <= hidx_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      hdr_q  <= '0;
    end else if (dat_en) begin
      addr_q <= addr_n;
      rem_q  <= rem_n;
      hdr_q  <= hdr_n;
    end
  end

  assign head_phase = (st_q == ST_HEAD);
  assign head_idx   = hidx_q;
  assign wr_addr    = head_phase ? hdr_q + AW'(hidx_q) : addr_q;
  assign state      = st_q;
  assign err_code   = err_q;

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |-> (!wr_valid && !dsc_req && !in_ready));

  p_fetch_posted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH && $past(st_q == ST_WAIT)) |-> $past(avail));

  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && enable) |=> (st_q == ST_HALT));

  p_drain_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && enable) |=> (st_q == ST_DRAIN || st_q == ST_HEAD));

  p_halt_coded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT) |-> (err_q != ERR_NONE));

  p_off_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st_q == ST_OFF && err_q == ERR_NONE));

endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
  import rxring_pkg::*;
#(
  parameter int AW        = 32,
  parameter int RING_BITS = 12,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          ctrl_word,
  input  logic [AW-1:0]        ring_base,
  input  logic [RING_BITS-1:0] last_post,
  output logic [31:0]          status_word,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  input  logic                 in_last,
  output logic                 in_ready,
  output logic                 dsc_req,
  output logic [AW-1:0]        dsc_addr,
  input  logic                 dsc_ack,
  input  logic                 dsc_err,
  input  logic [31:0]          dsc_ctrl,
  input  logic [AW-1:0]        dsc_buf,
  output logic                 wr_valid,
  output logic [AW-1:0]        wr_addr,
  output logic [7:0]           wr_data,
  input  logic                 wr_ready,
  input  logic                 wr_err,
  output logic                 frame_done
);

  localparam int DSC_STEP = 8;

  logic [RING_BITS-1:0] cur;
  rx_state_e            state;
  logic [3:0]           err_code;
  logic                 head_phase;
  logic [1:0]           head_idx;
  logic                 ptr_clr, ptr_adv, ptr_wrap;
  logic                 acc_start, acc_next, acc_byte, acc_ovf, acc_fin;
  logic [LEN_W-1:0]     f_len;
  logic [CNT_W-1:0]     f_cnt;
  logic                 f_ovf;
  logic                 avail;
  logic [3:0]           stc;
  logic                 unused_bits;

  assign avail    = (cur != last_post);
  assign dsc_addr = {ring_base[AW-1:RING_BITS], cur};

  assign unused_bits = ^{ctrl_word[31:11], ctrl_word[9:8], ring_base[RING_BITS-1:0],
                         dsc_ctrl[31:30], dsc_ctrl[27:DSC_BC_W]};

  rxring_ptr #(.RING_BITS(RING_BITS), .STEP(DSC_STEP)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ptr_clr),
    .adv  (ptr_adv),
    .wrap (ptr_wrap),
    .cur  (cur)
  );

  rxring_fsm #(.AW(AW), .BC_W(DSC_BC_W), .OFS_W(CTL_OFS_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (ctrl_word[CTL_EN]),
    .ovf_cont  (ctrl_word[CTL_OVC]),
    .ofs       (ctrl_word[CTL_OFS_LSB +: CTL_OFS_W]),
    .avail     (avail),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .dsc_req   (dsc_req),
    .dsc_ack   (dsc_ack),
    .dsc_err   (dsc_err),
    .dsc_bc    (dsc_ctrl[DSC_BC_W-1:0]),
    .dsc_eot   (dsc_ctrl[DSC_EOT]),
    .dsc_buf   (dsc_buf),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_ready  (wr_ready),
    .wr_err    (wr_err),
    .state     (state),
    .err_code  (err_code),
    .head_phase(head_phase),
    .head_idx  (head_idx),
    .ptr_clr   (ptr_clr),
    .ptr_adv   (ptr_adv),
    .ptr_wrap  (ptr_wrap),
    .acc_start (acc_start),
    .acc_next  (acc_next),
    .acc_byte  (acc_byte),
    .acc_ovf   (acc_ovf),
    .acc_fin   (acc_fin)
  );

  rxring_acc #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (acc_start),
    .next   (acc_next),
    .byte_ok(acc_byte),
    .set_ovf(acc_ovf),
    .fin    (acc_fin),
    .ioc_in (dsc_ctrl[DSC_IOC]),
    .len    (f_len),
    .cnt    (f_cnt),
    .ovf    (f_ovf),
    .done   (frame_done)
  );

  assign wr_data = head_phase ? hdr_byte(16'(f_len), f_ovf, 4'(f_cnt), head_idx) : in_data;

  always_comb begin
    case (state)
      ST_OFF:  stc = STC_OFF;
      ST_WAIT: stc = STC_WAIT;
      ST_HALT: stc = STC_HALT;
      default: stc = STC_RUN;
    endcase
    status_word                  = '0;
    status_word[RING_BITS-1:0]   = cur;
    status_word[15:12]           = stc;
    status_word[19:16]           = err_code;
  end

  p_wait_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !avail) |=> (state == ST_WAIT || !ctrl_word[CTL_EN]));

  p_halt_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> (!wr_valid && !in_ready));

endmodule

// File: tb/rxring_dma_test.sv
`timescale 1ns/100ps
module rxring_dma_test;

  logic        clk;
  logic        rst_n;
  logic [31:0] ctrl_word;
  logic [31:0] ring_base;
  logic [11:0] last_post;
  logic [31:0] status_word;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_last;
  logic        in_ready;
  logic        dsc_req;
  logic [31:0] dsc_addr;
  logic        dsc_ack;
  logic        dsc_err;
  logic [31:0] dsc_ctrl;
  logic [31:0] dsc_buf;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_ready;
  logic        wr_err;
  logic        frame_done;

  int total = 0;
  int bad   = 0;

  logic [31:0] dctl [0:7];
  logic [31:0] dbuf [0:7];
  logic [7:0]  mem  [0:4095];
  logic        stall_en, tick, mem_clr, dsc_err_inj, werr_inj;
  int          wcount, done_cnt, dreq_cnt, addr_bad;

  rxring_dma uut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ring_base(ring_base),
    .last_post(last_post), .status_word(status_word), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready), .dsc_req(dsc_req),
    .dsc_addr(dsc_addr), .dsc_ack(dsc_ack), .dsc_err(dsc_err), .dsc_ctrl(dsc_ctrl),
    .dsc_buf(dsc_buf), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_err(wr_err), .frame_done(frame_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign dsc_ack  = dsc_req;
  assign dsc_err  = dsc_err_inj;
  assign dsc_ctrl = dctl[dsc_addr[5:3]];
  assign dsc_buf  = dbuf[dsc_addr[5:3]];
  assign wr_ready = !(stall_en && tick);
  assign wr_err   = werr_inj;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= 1'b0; wcount <= 0; done_cnt <= 0; dreq_cnt <= 0; addr_bad <= 0;
    end else begin
      tick <= ~tick;
      if (wr_valid && wr_ready) wcount <= wcount + 1;
      if (frame_done) done_cnt <= done_cnt + 1;
      if (dsc_req && dsc_ack) begin
        dreq_cnt <= dreq_cnt + 1;
        if (dsc_addr[31:12] != ring_base[31:12]) addr_bad <= addr_bad + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (mem_clr) begin
      for (int a = 0; a < 4096; a++) mem[a] <= 8'h00;
    end else if (wr_valid && wr_ready && !wr_err) begin
      mem[wr_addr[11:0]] <= wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'(i * 13 + s * 5 + 1);
  endfunction

  function automatic int bufa(input int j);
    return (j % 4 + 1) * 256;
  endfunction

  function automatic int pos_of(input int i, input int off, input int first);
    int cap0 = 16 - off;
    if (i < cap0) return bufa(first) + off + i;
    return bufa(first + (i - cap0) / 16 + 1) + (i - cap0) % 16;
  endfunction

  function automatic int st_word(input int err, input int stc, input int cur);
    return (err << 16) | (stc << 12) | cur;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [31:0] c, input logic [11:0] lp);
    @(negedge clk);
    ctrl_word = 32'h0;
    mem_clr   = 1'b1;
    @(negedge clk);
    mem_clr   = 1'b0;
    @(negedge clk);
    last_post = lp;
    ctrl_word = c;
    idle(2);
  endtask

  task automatic send_frame(input int len, input int seed, output bit gave);
    gave = 1'b0;
    for (int i = 0; i < len; i++) begin
      int w = 0;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pat(i, seed);
      in_last  = (i == len - 1);
      #1;
      while (!in_ready && w < 40) begin
        @(negedge clk);
        #1;
        w++;
      end
      if (w >= 40) begin
        gave = 1'b1;
        break;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic check_frame(input string req, input int len, input int stored, input int off,
                             input int first, input int n, input bit ovf);
    int errs = 0;
    int b = bufa(first);
    logic [31:0] got, exp;
    for (int i = 0; i < stored; i++)
      if (mem[pos_of(i, off, first)] != pat(i, len)) errs++;
    chk(errs == 0, req, errs, 0);
    got = {mem[b + 3], mem[b + 2], mem[b + 1], mem[b]};
    exp = (32'(n - 1) << 24) | (32'(ovf) << 23) | 32'(stored);
    chk(got == exp, "R5", got, exp);
  endtask

  initial begin
    int w0, d0, r0, n, cap0;
    bit gave;
    rst_n = 1'b0; ctrl_word = 0; ring_base = 32'h0004_5000; last_post = 0;
    in_valid = 0; in_data = 0; in_last = 0; stall_en = 0; mem_clr = 1'b1;
    dsc_err_inj = 0; werr_inj = 0;
    for (int i = 0; i < 8; i++) begin
      dctl[i] = 32'd16 | ((i == 3) ? (32'h1 << 28) : 32'h0);
      dbuf[i] = 32'((i % 4 + 1) * 256);
    end
    idle(3);
    rst_n = 1'b1;
    idle(2);
    mem_clr = 1'b0;
    // R1: reset state
    chk(status_word == 0, "R1", status_word, 0);
    chk(!in_ready && !wr_valid && !dsc_req, "R1", {in_ready, wr_valid, dsc_req}, 0);

    // R2: enabled, nothing posted
    restart(32'h9, 12'd0);
    chk(status_word == st_word(0, 2, 0), "R2", status_word, st_word(0, 2, 0));
    r0 = dreq_cnt;
    @(negedge clk); in_valid = 1'b1; in_data = 8'h55;
    idle(6);
    chk(!in_ready && dreq_cnt == r0, "R2", dreq_cnt - r0, 0);
    in_valid = 1'b0;

    // R3 R4 R5: sweep lengths and offsets over three posted descriptors
    for (int oi = 0; oi < 3; oi++) begin
      int off = (oi == 0) ? 4 : (oi == 1) ? 7 : 12;
      stall_en = (oi == 1);
      cap0 = 16 - off;
      for (int L = 1; L <= cap0 + 32; L++) begin
        restart(32'h1 | 32'(off << 1), 12'd24);
        w0 = wcount; d0 = done_cnt;
        send_frame(L, L, gave);
        idle(16);
        n = (L <= cap0) ? 1 : 1 + (L - cap0 + 15) / 16;
        chk(!gave, "R3", gave, 0);
        check_frame("R3", L, L, off, 0, n, 1'b0);
        chk(status_word == st_word(0, 2, 8 * n), "R4", status_word, st_word(0, 2, 8 * n));
        chk(wcount - w0 == L + 4, "R3", wcount - w0, L + 4);
        chk(done_cnt == d0, "R10", done_cnt - d0, 0);
      end
    end
    stall_en = 1'b0;
    chk(addr_bad == 0, "R2", addr_bad, 0);

    // R4: wrap after end-of-ring descriptor
    restart(32'h9, 12'd8);
    send_frame(12, 12, gave);
    idle(12);
    chk(status_word == st_word(0, 2, 8), "R4", status_word, st_word(0, 2, 8));
    @(negedge clk); last_post = 12'd0;
    send_frame(44, 44, gave);
    idle(12);
    check_frame("R4", 44, 44, 4, 1, 3, 1'b0);
    chk(status_word == st_word(0, 2, 0), "R4", status_word, st_word(0, 2, 0));

    // R6: overflow stops the channel
    restart(32'h9, 12'd16);
    w0 = wcount;
    send_frame(40, 40, gave);
    idle(4);
    chk(status_word == st_word(2, 3, 16), "R6", status_word, st_word(2, 3, 16));
    chk(wcount - w0 == 28 && !in_ready, "R6", wcount - w0, 28);
    // R11: disable clears on the next edge
    @(negedge clk); ctrl_word = 32'h0;
    @(negedge clk);
    chk(status_word == 0, "R11", status_word, 0);

    // R7: overflow with continue
    restart(32'h409, 12'd16);
    w0 = wcount;
    send_frame(40, 40, gave);
    idle(12);
    chk(!gave, "R7", gave, 0);
    chk(wcount - w0 == 32, "R7", wcount - w0, 32);
    check_frame("R7", 40, 28, 4, 0, 2, 1'b1);
    chk(status_word == st_word(0, 2, 16), "R7", status_word, st_word(0, 2, 16));
    @(negedge clk); last_post = 12'd24;
    send_frame(5, 5, gave);
    idle(12);
    check_frame("R7", 5, 5, 4, 2, 1, 1'b0);
    chk(status_word == st_word(0, 2, 24), "R7", status_word, st_word(0, 2, 24));

    // R8: descriptor protocol errors
    restart(32'h1 | (32'd16 << 1), 12'd24);
    send_frame(3, 3, gave);
    chk(status_word == st_word(1, 3, 0), "R8", status_word, st_word(1, 3, 0));
    dctl[0] = 32'h0;
    restart(32'h9, 12'd24);
    send_frame(3, 3, gave);
    chk(status_word == st_word(1, 3, 0), "R8", status_word, st_word(1, 3, 0));
    dctl[0] = 32'd16;

    // R9: bus errors
    dsc_err_inj = 1'b1;
    restart(32'h9, 12'd24);
    send_frame(3, 3, gave);
    chk(status_word == st_word(4, 3, 0), "R9", status_word, st_word(4, 3, 0));
    dsc_err_inj = 1'b0;
    werr_inj = 1'b1;
    restart(32'h9, 12'd24);
    send_frame(3, 3, gave);
    chk(status_word == st_word(3, 3, 8), "R9", status_word, st_word(3, 3, 8));
    werr_inj = 1'b0;

    // R10: notify flag on the second descriptor
    dctl[1] = 32'd16 | (32'h1 << 29);
    restart(32'h9, 12'd24);
    d0 = done_cnt;
    send_frame(20, 20, gave);
    idle(12);
    chk(done_cnt - d0 == 1, "R10", done_cnt - d0, 1);
    send_frame(5, 5, gave);
    idle(12);
    chk(done_cnt - d0 == 1, "R10", done_cnt - d0, 1);
    dctl[1] = 32'd16;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule